// File: doc/BRIEF.md
# Inbound Doorbell Queue Controller

This block receives doorbell notifications that a link layer has already decoded into a source ID, a target ID and a 16-bit info word, presented for one cycle on a valid strobe. Each accepted doorbell is packed into an 8-byte entry and stored in a circular queue held in a local buffer. The controller tracks the queue with a dequeue pointer and an enqueue pointer, both byte addresses into the buffer.

Software drives the block through a small register port. It sets up both pointers, clears stale status, and then enables the unit. After that it reads the entry at the dequeue pointer as two 32-bit words and retires it with a command bit in the mode register. A sticky status register has bits for reception errors, queue-full drops and pending entries. Writing a one to a status bit clears it. An interrupt line is raised while any status bit is set.

Top module: `doorbell_inq`

Register map (3-bit address, 32-bit data): 0 = mode, 1 = status, 2 = dequeue pointer, 3 = enqueue pointer, 4 = entry bytes 0..3 at the dequeue pointer, 5 = entry bytes 4..7 at the dequeue pointer. Pointer registers read back as the byte pointer zero-extended to 32 bits.

## Requirements
- R1: After reset, mode, status, dequeue pointer and enqueue pointer all read 0, and intReq is low.
- R2: An entry is big-endian, with byte 0 at bits 63:56. The target ID sits in byte 3, the source ID in byte 5, and the info word in bytes 6 (high byte) and 7 (low byte). All other bytes are zero. So address 4 reads {24'h0, target} and address 5 reads {8'h0, source, info}.
- R3: A doorbell that arrives while enabled and not full is written at the enqueue pointer, and the enqueue pointer advances by 8 on that clock edge.
- R4: Mode bit 0 is the enable and is stored as written. Writing mode with bit 1 set retires the head entry and advances the dequeue pointer by 8. Bit 1 always reads back as 0, and the other mode bits read back as written.
- R5: A dequeue command given while the queue is empty (pointers equal) leaves the dequeue pointer unchanged.
- R6: The queue is full when the enqueue pointer plus 8 (modulo the buffer size) equals the dequeue pointer, so it holds DEPTH-1 entries. A doorbell that arrives while full is dropped, the enqueue pointer does not move, and status bit 4 (0x10) is set.
- R7: A doorbell that arrives while mode bit 0 is clear is dropped, the enqueue pointer does not move, and status bit 7 (0x80) is set.
- R8: Status bit 0 (0x01) is set again on every clock while the two pointers differ. A write-one-to-clear on it takes effect only once the queue has been drained.
- R9: Writing status clears each bit written as 1 (bits 7, 4, 0) and leaves bits written as 0 unchanged.
- R10: Both pointers wrap from the last entry (byte offset DEPTH*8-8) back to offset 0.
- R11: A software write to a pointer register loads the pointer from the low bits of the data, with bits 2:0 forced to zero.
- R12: intReq is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bellValid | input | 1 | Doorbell present this cycle |
| bellSrcId | input | 8 | Source ID of the doorbell |
| bellTgtId | input | 8 | Target ID of the doorbell |
| bellInfo | input | 16 | Info word of the doorbell |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| intReq | output | 1 | Interrupt request, OR of the status bits |

## Verification
The bench builds the block with DEPTH set to 8, so the buffer spans 64 bytes. With that size, filling the queue to its 7-entry limit, the dropped eighth doorbell and both pointer wraps each take only a handful of operations. These cases are driven as directed sequences. A seeded random mix of doorbells and dequeue commands then crosses the full and empty limits and the wrap point many times. A bench model predicts the pointers and the head entry after every operation.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int REG_W   = 32;
  localparam int ID_W    = 8;
  localparam int INFO_W  = 16;
  localparam int ENTRY_W = 64;

  localparam int MODE_EN  = 0;
  localparam int MODE_POP = 1;
  localparam int ST_ERR   = 7;
  localparam int ST_FULL  = 4;
  localparam int ST_PEND  = 0;

  typedef enum logic [2:0] {
    RA_MODE   = 3'd0,
    RA_STATUS = 3'd1,
    RA_DEQ    = 3'd2,
    RA_ENQ    = 3'd3,
    RA_ENT_HI = 3'd4,
    RA_ENT_LO = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic setErr;
    logic setFull;
    logic ldDeq;
    logic ldEnq;
  } dbqStrobe_t;
endpackage

// File: rtl/dbq_data.sv
module dbq_data
  import dbq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dbqStrobe_t         strb,
  input  logic [ID_W-1:0]    srcId,
  input  logic [ID_W-1:0]    tgtId,
  input  logic [INFO_W-1:0]  info,
  input  logic [REG_W-1:0]   wrData,
  output logic [PTR_W-1:0]   deqPtr,
  output logic [PTR_W-1:0]   enqPtr,
  output logic               qFull,
  output logic               qEmpty,
  output logic [ENTRY_W-1:0] headEntry
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(8);

  logic [ENTRY_W-1:0] bufMem [DEPTH];
  logic [ENTRY_W-1:0] newEntry;
  logic [PTR_W-1:0]   loadVal;

  // byte 3 = target, byte 5 = source, bytes 6..7 = info (big-endian)
  assign newEntry = {24'h0, tgtId, 8'h0, srcId, info};
  assign loadVal  = {wrData[PTR_W-1:3], 3'b000};

  assign qEmpty    = (deqPtr == enqPtr);
  assign qFull     = ((enqPtr + STEP) == deqPtr);
  assign headEntry = bufMem[deqPtr[PTR_W-1:3]];

  always_ff @(posedge clk) begin
    if (strb.push) bufMem[enqPtr[PTR_W-1:3]] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deqPtr <= '0;
      enqPtr <= '0;
    end else begin
      if (strb.ldDeq)    deqPtr <= loadVal;
      else if (strb.pop) deqPtr <= deqPtr + STEP;
      if (strb.ldEnq)     enqPtr <= loadVal;
      else if (strb.push) enqPtr <= enqPtr + STEP;
    end
  end
endmodule

// File: rtl/dbq_ctrl.sv
module dbq_ctrl
  import dbq_pkg::*;
#(
  parameter int PTR_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bellValid,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               qFull,
  input  logic               qEmpty,
  input  logic [PTR_W-1:0]   deqPtr,
  input  logic [PTR_W-1:0]   enqPtr,
  input  logic [ENTRY_W-1:0] headEntry,
  output dbqStrobe_t         strb,
  output logic [REG_W-1:0]   regRdData,
  output logic               modeEn,
  output logic [7:0]         statusOut,
  output logic               intReq
);
  logic [REG_W-1:0] modeReg;
  logic [7:0]       clrMask;
  logic [7:0]       setMask;
  logic [7:0]       statusReg;
  logic             wrMode, wrStat;

  assign wrMode = regWrEn && (regAddr == RA_MODE);
  assign wrStat = regWrEn && (regAddr == RA_STATUS);
  assign modeEn = modeReg[MODE_EN];

  always_comb begin
    strb         = '0;
    strb.ldDeq   = regWrEn && (regAddr == RA_DEQ);
    strb.ldEnq   = regWrEn && (regAddr == RA_ENQ);
    strb.pop     = wrMode && regWrData[MODE_POP] && !qEmpty;
    strb.push    = bellValid && modeEn && !qFull;
    strb.setErr  = bellValid && !modeEn;
    strb.setFull = bellValid && modeEn && qFull;
  end

  always_comb begin
    clrMask = wrStat ? regWrData[7:0] : 8'h00;
    setMask = 8'h00;
    setMask[ST_ERR]  = strb.setErr;
    setMask[ST_FULL] = strb.setFull;
    setMask[ST_PEND] = !qEmpty;
  end

  // the three status bits share one set-wins-over-clear update
  for (genvar b = 0; b < 8; b++) begin : g_stat
    if (b == ST_ERR || b == ST_FULL || b == ST_PEND) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN) statusReg[b] <= 1'b0;
        else       statusReg[b] <= (statusReg[b] & ~clrMask[b]) | setMask[b];
      end
    end else begin : g_tie
      assign statusReg[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       modeReg <= '0;
    else if (wrMode) modeReg <= regWrData & ~(REG_W'(1) << MODE_POP);
  end

  assign statusOut = statusReg;
  assign intReq    = |statusReg;

  always_comb begin
    case (regAddr)
      RA_MODE:   regRdData = modeReg;
      RA_STATUS: regRdData = REG_W'(statusReg);
      RA_DEQ:    regRdData = REG_W'(deqPtr);
      RA_ENQ:    regRdData = REG_W'(enqPtr);
      RA_ENT_HI: regRdData = headEntry[63:32];
      RA_ENT_LO: regRdData = headEntry[31:0];
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/doorbell_inq.sv
module doorbell_inq
  import dbq_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bellValid,
  input  logic [7:0]  bellSrcId,
  input  logic [7:0]  bellTgtId,
  input  logic [15:0] bellInfo,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        intReq
);
  localparam int PTR_W = $clog2(DEPTH) + 3;

  dbqStrobe_t         strb;
  logic [PTR_W-1:0]   deqPtr, enqPtr;
  logic               qFull, qEmpty, modeEn;
  logic [ENTRY_W-1:0] headEntry;
  logic [7:0]         statusOut;

  dbq_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bellValid(bellValid), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .qFull(qFull), .qEmpty(qEmpty),
    .deqPtr(deqPtr), .enqPtr(enqPtr), .headEntry(headEntry), .strb(strb),
    .regRdData(regRdData), .modeEn(modeEn), .statusOut(statusOut), .intReq(intReq)
  );

  dbq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .srcId(bellSrcId), .tgtId(bellTgtId),
    .info(bellInfo), .wrData(regWrData), .deqPtr(deqPtr), .enqPtr(enqPtr),
    .qFull(qFull), .qEmpty(qEmpty), .headEntry(headEntry)
  );
endmodule

// File: rtl/dbq_checker.sv
module dbq_checker #(
  parameter int PTR_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             bellValid,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             modeEn,
  input logic [7:0]       statusOut,
  input logic [PTR_W-1:0] deqPtr,
  input logic [PTR_W-1:0] enqPtr
);
  logic fullNow, enqLoad;
  assign fullNow = ((enqPtr + PTR_W'(8)) == deqPtr);
  assign enqLoad = regWrEn && (regAddr == 3'd3);

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    bellValid && modeEn && !fullNow && !enqLoad |=> enqPtr == $past(enqPtr) + PTR_W'(8));

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 3'd0 && regWrData[1] && deqPtr == enqPtr |=> $stable(deqPtr));

  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    bellValid && modeEn && fullNow && !enqLoad |=> $stable(enqPtr) && statusOut[4]);

  p_drop_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    bellValid && !modeEn && !enqLoad |=> $stable(enqPtr) && statusOut[7]);

  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    deqPtr != enqPtr |=> statusOut[0]);
endmodule

bind doorbell_inq dbq_checker #(.PTR_W(PTR_W)) u_dbq_checker (
  .clk(clk), .rstN(rstN), .bellValid(bellValid), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .modeEn(modeEn),
  .statusOut(statusOut), .deqPtr(deqPtr), .enqPtr(enqPtr)
);

// File: tb/test_doorbell_inq.sv
`timescale 1ns/1ps
module test_doorbell_inq;
  localparam int DEPTH = 8;
  localparam int SPAN  = DEPTH * 8;
  localparam logic [31:0] MODE_ON  = 32'h0010_8161;
  localparam logic [31:0] MODE_POP = 32'h0010_8163;

  logic clk = 0, rstN = 0, bellValid = 0, regWrEn = 0, intReq;
  logic [7:0] bellSrcId = 0, bellTgtId = 0;
  logic [15:0] bellInfo = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  int nChecks = 0, nErrors = 0;

  int mDeq, mEnq;
  logic [63:0] mMem [DEPTH];

  always #2.5 clk = ~clk;

  doorbell_inq #(.DEPTH(DEPTH)) i_doorbell_inq (
    .clk(clk), .rstN(rstN), .bellValid(bellValid), .bellSrcId(bellSrcId),
    .bellTgtId(bellTgtId), .bellInfo(bellInfo), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .intReq(intReq)
  );

  function automatic logic [63:0] fmtEntry(logic [7:0] s, logic [7:0] t, logic [15:0] i);
    return {24'h0, t, 8'h0, s, i};
  endfunction

  function automatic int nextPtr(int p);
    return (p + 8) % SPAN;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ringBell(input logic [7:0] s, input logic [7:0] t, input logic [15:0] i);
    @(negedge clk);
    bellValid = 1; bellSrcId = s; bellTgtId = t; bellInfo = i;
    @(negedge clk);
    bellValid = 0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #900000;
    nErrors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_0042));
    idle(3);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(3'(a), rd);
      chk("R1 reset register", rd, 32'h0);
    end
    chk("R1 reset intReq", 32'(intReq), 32'h0);

    // R7 disabled drop
    ringBell(8'h11, 8'h22, 16'h3333);
    regRead(3'd1, rd); chk("R7 error bit", rd, 32'h80);
    regRead(3'd3, rd); chk("R7 enq unchanged", rd, 32'h0);
    chk("R12 intReq with status", 32'(intReq), 32'h1);

    // R9 partial clear, then full clear
    regWrite(3'd1, 32'h10);
    regRead(3'd1, rd); chk("R9 unwritten bit kept", rd, 32'h80);
    regWrite(3'd1, 32'h91);
    regRead(3'd1, rd); chk("R9 cleared", rd, 32'h0);
    chk("R12 intReq idle", 32'(intReq), 32'h0);

    // R4 enable
    regWrite(3'd0, MODE_ON);
    regRead(3'd0, rd); chk("R4 mode readback", rd, MODE_ON);

    // R3/R2 push one
    ringBell(8'h12, 8'h34, 16'hABCD);
    regRead(3'd3, rd); chk("R3 enq advance", rd, 32'h8);
    regRead(3'd4, rd); chk("R2 entry hi", rd, 32'h0000_0034);
    regRead(3'd5, rd); chk("R2 entry lo", rd, 32'h0012_ABCD);
    idle(1);
    regRead(3'd1, rd); chk("R8 pending set", rd, 32'h01);
    regWrite(3'd1, 32'h01);
    regRead(3'd1, rd); chk("R8 pending resists clear", rd, 32'h01);

    // R4 pop
    regWrite(3'd0, MODE_POP);
    regRead(3'd2, rd); chk("R4 deq advance", rd, 32'h8);
    regRead(3'd0, rd); chk("R4 pop bit reads 0", rd, MODE_ON);
    regWrite(3'd1, 32'h01);
    regRead(3'd1, rd); chk("R8 clear after drain", rd, 32'h0);

    // R5 pop on empty
    regWrite(3'd0, MODE_POP);
    regRead(3'd2, rd); chk("R5 deq unchanged", rd, 32'h8);

    // R6 fill to capacity, R10 enq wrap
    for (int k = 0; k < DEPTH - 1; k++)
      ringBell(8'(k), 8'(k + 8'h40), 16'(16'h1000 + k));
    regRead(3'd3, rd); chk("R10 enq wrap", rd, 32'h0);
    regRead(3'd1, rd); chk("R6 no full yet", rd & 32'h10, 32'h0);
    ringBell(8'hEE, 8'hEE, 16'hEEEE);
    regRead(3'd3, rd); chk("R6 enq held when full", rd, 32'h0);
    regRead(3'd1, rd); chk("R6 full bit", rd, 32'h11);
    for (int k = 0; k < DEPTH - 1; k++) begin
      regRead(3'd4, rd); chk("R2 drain hi", rd, {24'h0, 8'(k + 8'h40)});
      regRead(3'd5, rd); chk("R2 drain lo", rd, {8'h0, 8'(k), 16'(16'h1000 + k)});
      regWrite(3'd0, MODE_POP);
    end
    regRead(3'd2, rd); chk("R10 deq wrap", rd, 32'h0);
    regWrite(3'd1, 32'h91);

    // R11 pointer loads
    regWrite(3'd2, 32'h2F);
    regRead(3'd2, rd); chk("R11 deq aligned load", rd, 32'h28);
    regWrite(3'd3, 32'h2B);
    regRead(3'd3, rd); chk("R11 enq aligned load", rd, 32'h28);

    // random phase against model
    mDeq = 32'h28; mEnq = 32'h28;
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 3) != 2) begin
        logic [7:0] s, t; logic [15:0] i;
        s = 8'($urandom); t = 8'($urandom); i = 16'($urandom);
        ringBell(s, t, i);
        if (nextPtr(mEnq) != mDeq) begin
          mMem[mEnq / 8] = fmtEntry(s, t, i);
          mEnq = nextPtr(mEnq);
        end
      end else begin
        regWrite(3'd0, MODE_POP);
        if (mDeq != mEnq) mDeq = nextPtr(mDeq);
      end
      regRead(3'd2, rd); chk("R4 random deq", rd, 32'(mDeq));
      regRead(3'd3, rd); chk("R3 random enq", rd, 32'(mEnq));
      if (mDeq != mEnq) begin
        regRead(3'd4, rd); chk("R2 random hi", rd, mMem[mDeq / 8][63:32]);
        regRead(3'd5, rd); chk("R2 random lo", rd, mMem[mDeq / 8][31:0]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule